// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Latched Condition Flags

This block is the arithmetic/logic unit of a small load/store processor. It takes two operand words, one from each of the processor's two operand buses, and a 3-bit function code from the current instruction. From these it forms a single result. That result feeds the register write-back path and also drives a second copy onto the second bus. The result path is purely combinational.

Beside the result, the unit keeps two condition flags in a small clocked register. The flags are captured only on cycles where the control logic issues an ALU command. The zero flag has inverted polarity: it reads 0 when the last commanded result was zero and 1 otherwise. The negative flag reads 1 when that result's sign bit was set.

Register-register and register-literal forms of an operation look the same to this unit. A literal is already sitting on the B input by the time the unit sees it, and that includes a literal used as a shift amount.

Top module: `alu_cc_unit`

## Requirements
- R1: Function code 000 gives A+B and 001 gives A-B, both wrapping modulo 2^32.
- R2: Function code 010 gives A&B, 011 gives A|B and 100 gives A^B.
- R3: Function code 101 shifts A left and fills with zeros. Code 110 shifts A right and fills with zeros. Code 111 shifts A right and fills with copies of A's bit 31. The shift amount is B[4:0], and bits 31:5 of B have no effect on the result.
- R4: A shift whose amount B[4:0] is 0 returns A unchanged.
- R5: `res_wb` and `res_bus` always carry the same value.
- R6: On a rising clock edge with `cmd_en`=1, `flag_nz` (zero flag) takes the value 0 if the result is zero and 1 otherwise.
- R7: On a rising clock edge with `cmd_en`=1, `flag_neg` (negative flag) takes bit 31 of the result.
- R8: On a rising clock edge with `cmd_en`=0, both flags keep their values, even though the result output still follows the inputs.
- R9: While `rst_n` is low, `flag_nz` reads 1 and `flag_neg` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| cmd_en | input | 1 | ALU command this cycle; enables flag capture |
| func | input | 3 | Function code from the instruction |
| op_a | input | 32 | Operand A from the first bus |
| op_b | input | 32 | Operand B (register or literal) from the second bus |
| res_wb | output | 32 | Result toward register write-back |
| res_bus | output | 32 | Result driven onto the second bus |
| flag_nz | output | 1 | Zero flag, inverted: 0 when the last commanded result was zero |
| flag_neg | output | 1 | Negative flag: 1 when the last commanded result was negative |

## Verification
Two things happen in the same cycle, and the bench has to tell them apart: the combinational result changing for a new operation, and the flag register capturing or holding the previous state. The bench forces the conflict by following a commanded operation that gives a zero or negative result with an uncommanded operation that gives a different result. It then checks two things after the edge. First, the result ports must show the new value. Second, the flags must still reflect the last commanded result. The bench also sends back-to-back commanded operations whose flag outcomes alternate, so that every edge must take the current cycle's result and not a stale one.

// File: rtl/alu_cc_unit.sv
module alu_cc_unit #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_en,
  input  logic [2:0]   func,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] res_wb,
  output logic [W-1:0] res_bus,
  output logic         flag_nz,
  output logic         flag_neg
);

  logic [SW-1:0] sh_amt;
  logic [W-1:0]  result;

  assign sh_amt = op_b[SW-1:0];

  always_comb begin
    unique case (func)
      3'b000: result = op_a + op_b;
      3'b001: result = op_a - op_b;
      3'b010: result = op_a & op_b;
      3'b011: result = op_a | op_b;
      3'b100: result = op_a ^ op_b;
      3'b101: result = op_a << sh_amt;
      3'b110: result = op_a >> sh_amt;
      default: result = W'($signed(op_a) >>> sh_amt);
    endcase
  end

  assign res_wb  = result;
  assign res_bus = result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_nz  <= 1'b1;
      flag_neg <= 1'b0;
    end else if (cmd_en) begin
      flag_nz  <= |result;
      flag_neg <= result[W-1];
    end
  end

endmodule

module alu_cc_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_en,
  input logic [2:0]   func,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] res_wb,
  input logic         flag_nz,
  input logic         flag_neg
);

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |=> flag_nz == ($past(res_wb) != '0));

  a_r7_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |=> flag_neg == $past(res_wb[W-1]));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |=> $stable(flag_nz) && $stable(flag_neg));

  a_r4_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (func >= 3'b101 && op_b[4:0] == 5'd0) |-> res_wb == op_a);

  a_r3_sra_sign: assert property (@(posedge clk) disable iff (!rst_n)
    func == 3'b111 |-> res_wb[W-1] == op_a[W-1]);

  a_r3_srl_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 3'b110 && op_b[4:0] != 5'd0) |-> res_wb[W-1] == 1'b0);

endmodule

bind alu_cc_unit alu_cc_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .func(func),
  .op_a(op_a), .op_b(op_b), .res_wb(res_wb),
  .flag_nz(flag_nz), .flag_neg(flag_neg)
);

// File: tb/sim_alu_cc_unit.sv
module sim_alu_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_en = 1'b0;
  logic [2:0]  func = 3'b000;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] res_wb, res_bus;
  logic        flag_nz, flag_neg;

  int checks = 0;
  int failures = 0;
  logic m_nz = 1'b1;
  logic m_neg = 1'b0;

  logic [33:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  alu_cc_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .func(func),
    .op_a(op_a), .op_b(op_b), .res_wb(res_wb), .res_bus(res_bus),
    .flag_nz(flag_nz), .flag_neg(flag_neg)
  );

  function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    int n;
    n = int'(b[4:0]);
    case (f)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << n;
      3'd6: return a >> n;
      default: return 32'($signed(a) >>> n);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic en, input string tag);
    logic [31:0] r;
    @(negedge clk);
    func = f; op_a = a; op_b = b; cmd_en = en;
    r = model(f, a, b);
    if (en) begin
      m_nz = (r != 32'd0);
      m_neg = r[31];
    end
    exp_q.push_back({m_nz, m_neg, r});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [33:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(res_wb === e[31:0], t, res_wb, e[31:0]);
      check(res_bus === e[31:0], {t, "/R5"}, res_bus, e[31:0]);
      check({flag_nz, flag_neg} === e[33:32], {t, "/flags"},
            {30'd0, flag_nz, flag_neg}, {30'd0, e[33:32]});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({flag_nz, flag_neg} === 2'b10, "R9 reset flags", {30'd0, flag_nz, flag_neg}, 32'd2);
    @(negedge clk);
    rst_n = 1'b1;

    drive(3'd0, 32'd5, 32'd7, 1'b1, "R1 add");
    drive(3'd0, 32'hFFFF_FFFF, 32'd1, 1'b1, "R1 add wrap to zero R6");
    drive(3'd1, 32'd3, 32'd5, 1'b1, "R1 sub negative R7");
    drive(3'd1, 32'd9, 32'd9, 1'b1, "R1 sub zero R6");
    drive(3'd2, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, "R2 and");
    drive(3'd3, 32'h8000_0000, 32'h0000_0001, 1'b1, "R2 or R7");
    drive(3'd4, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b1, "R2 xor zero R6");
    drive(3'd5, 32'h0000_0003, 32'd4, 1'b1, "R3 sll");
    drive(3'd5, 32'h0000_0001, 32'hFFFF_FFFF, 1'b1, "R3 sll upper B ignored");
    drive(3'd6, 32'h8000_0000, 32'd31, 1'b1, "R3 srl zero fill");
    drive(3'd7, 32'h8000_0000, 32'd4, 1'b1, "R3 sra sign fill");
    drive(3'd7, 32'h7000_0000, 32'h0000_0104, 1'b1, "R3 sra positive upper B ignored");
    drive(3'd5, 32'hDEAD_BEEF, 32'hFFFF_FFE0, 1'b1, "R4 sll by 0");
    drive(3'd6, 32'hDEAD_BEEF, 32'd0, 1'b1, "R4 srl by 0");
    drive(3'd7, 32'hCAFE_0001, 32'd32, 1'b1, "R4 sra by 0");
    drive(3'd1, 32'd10, 32'd10, 1'b1, "R6 zero captured");
    drive(3'd0, 32'd1, 32'd2, 1'b0, "R8 hold after zero");
    drive(3'd1, 32'd0, 32'd1, 1'b0, "R8 hold negative result uncommanded");
    drive(3'd1, 32'd0, 32'd1, 1'b1, "R7 negative captured");
    drive(3'd0, 32'd0, 32'd0, 1'b0, "R8 hold after negative");
    drive(3'd0, 32'd4, 32'd4, 1'b1, "R6 R7 positive captured");
    for (int i = 0; i < 8; i++) begin
      drive(3'(i), 32'h1357_9BDF + 32'(i), 32'd3 + 32'(i), 1'(i % 2), "R1 R2 R3 sweep");
    end
    @(negedge clk);
    cmd_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check({flag_nz, flag_neg} === 2'b10, "R9 async reset", {30'd0, flag_nz, flag_neg}, 32'd2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule